// File: doc/BRIEF.md
# Multi-Channel Output Compare Unit

This block watches an externally supplied free-running count and compares it against five programmable 16-bit compare values. When the count reaches a channel's value on an advance of the counter, and that channel is enabled, the block latches a per-channel event flag. It also raises a level interrupt while any enabled channel has its flag set. Software services the interrupt by reading the flag byte and writing ones to the bits it has handled.

The counter is not part of the block. A strobe marks the cycles in which the counter takes a new value, so a prescaled counter produces one comparison per count value and not one per clock. Each compare value is reached again every 65536 advances, so a channel fires periodically until software disables or reprograms it. All registers sit on a byte-wide bus with single-cycle writes and a combinational read path.

Top module: `ocu_top`

## Requirements
- R1: The five compare values are 16-bit registers. Channel k (k = 1..5) keeps its high byte at byte address 2(k-1) and its low byte at 2(k-1)+1. Each byte is written on its own and reads back as written. All compare values reset to 0xFFFF.
- R2: The enable byte is at address 10 and the flag byte at address 11. Channel k owns bit 8-k of both bytes, so channel 1 is bit 7 and channel 5 is bit 3. Bits 2..0 of both bytes read as zero, and writes to those bits have no effect. Both bytes reset to 0x00.
- R3: Suppose that in one clock cycle the counter strobe is high, the count input equals a channel's compare value and that channel's enable bit is 1. The channel's flag is then set at the end of that cycle and reads as 1 from the next cycle on.
- R4: No flag is set when the count equals a compare value while the strobe is low, or when the channel's enable bit is 0. Enabling the channel later does not set the flag either.
- R5: Writing the flag byte clears every flag whose written bit is 1 and leaves flags written with 0 unchanged. If a channel matches in the same cycle that its flag is cleared, the flag stays set.
- R6: The interrupt output is high exactly when some channel has both its flag and its enable bit set. Clearing an enable bit drops that channel's contribution but does not clear its flag.
- R7: A compare-byte write takes effect at the end of its cycle. A strobe in the same cycle is compared against the old value, and strobes in later cycles are compared against the new value.
- R8: A channel that matched and was cleared matches again when the count returns to the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Current value of the free-running counter |
| cnt_tick | input | 1 | High in cycles where cnt_val holds a newly reached count |
| bus_addr | input | 4 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, OR over channels of flag AND enable |

## Verification
Matches are tried with these count patterns: a value one below the compare value, an exact value, several channels matching one after another, a repeat of a value after its flag was cleared, and an equal value with the strobe low. Together they separate exact-equality detection from off-by-one errors and from matching on every cycle. Enable patterns with a single channel off show whether the mask gates the setting of a flag or only the interrupt. Writing flag bytes of all zeros, single ones and all ones tells write-one-to-clear apart from plain storage. Writes that coincide with a strobe fix on which side of the edge a new compare value or a clear takes effect.

// File: rtl/ocu_pkg.sv
// Package: shared constants and helpers for the output compare unit.
// Assumes a byte-wide register bus and channels mapped from bit 7 downward.
package ocu_pkg;
    localparam int DATA_W = 8;

    // Register byte bit owned by channel index ch (0-based).
    function automatic int chan_bit(input int ch);
        return DATA_W - 1 - ch;
    endfunction
endpackage

// File: rtl/ocu_chan.sv
// Module: one compare channel. Holds a 16-bit compare value written as two
// bytes (high at the even address) and flags a hit when the counter strobe
// is high, the count equals the stored value and the channel is enabled.
// Assumes CNT_W is 16 (two bytes).
module ocu_chan #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int IDX    = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ocu_pkg::DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]         cnt_val,
    input  logic                     cnt_tick,
    input  logic                     en,
    output logic [CNT_W-1:0]         cmp_q,
    output logic                     hit
);
    localparam int DW = ocu_pkg::DATA_W;
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 * IDX);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 * IDX + 1);

    logic wr_hi, wr_lo;

    // Byte write decode for this channel.
    always_comb begin
        wr_hi = wr && (addr == HI_ADDR);
        wr_lo = wr && (addr == LO_ADDR);
    end

    // Compare value storage, reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else begin
            if (wr_hi) cmp_q[CNT_W-1 -: DW] <= wdata;
            if (wr_lo) cmp_q[DW-1:0]        <= wdata;
        end
    end

    // Match detection against the stored (pre-write) value.
    always_comb begin
        hit = cnt_tick && en && (cmp_q == cnt_val);
    end

    AST_CMP_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_hi) |-> (cmp_q[CNT_W-1 -: DW] == $past(wdata))); // R1
    AST_CMP_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_lo) |-> (cmp_q[DW-1:0] == $past(wdata))); // R7
endmodule

// File: rtl/ocu_flags.sv
// Module: per-channel event flags. A hit sets a flag, a clear request
// resets it, and a hit in the same cycle as a clear wins.
// Assumes set and clr are single-cycle requests from the channel logic and
// the bus decode.
module ocu_flags #(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] flag_q
);
    // Flag register: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= set | (flag_q & ~clr);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[g]) |-> $past(set[g])); // R4
        AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && set[g]) |-> flag_q[g]); // R3
        AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && clr[g] && !set[g]) |-> !flag_q[g]); // R5
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && flag_q[g] && !clr[g]) |-> flag_q[g]); // R5
    end
endmodule

// File: rtl/ocu_rdmux.sv
// Module: combinational read path. Selects a compare byte, the enable byte
// or the flag byte by address; unused bits and unmapped addresses read 0.
// Assumes channel bits are packed from the byte's MSB downward.
module ocu_rdmux #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cmp,
    input  logic [NUM_CH-1:0]             mask,
    input  logic [NUM_CH-1:0]             flag,
    output logic [ocu_pkg::DATA_W-1:0]    rdata
);
    localparam int DW = ocu_pkg::DATA_W;
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(2 * NUM_CH);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * NUM_CH + 1);

    // Address-indexed byte select.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(2 * i))     rdata = cmp[i][CNT_W-1 -: DW];
            if (addr == ADDR_W'(2 * i + 1)) rdata = cmp[i][DW-1:0];
        end
        if (addr == MASK_ADDR)
            for (int i = 0; i < NUM_CH; i++) rdata[ocu_pkg::chan_bit(i)] = mask[i];
        if (addr == FLAG_ADDR)
            for (int i = 0; i < NUM_CH; i++) rdata[ocu_pkg::chan_bit(i)] = flag[i];
    end
endmodule

// File: rtl/ocu_top.sv
// Module: multi-channel output compare unit. Compares an external count,
// sampled on its advance strobe, against NUM_CH compare values, latches
// per-channel flags gated by an enable byte and drives a combined interrupt.
// Assumes NUM_CH <= 8 and a 16-bit count; the counter itself is external.
module ocu_top #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt_val,
    input  logic                       cnt_tick,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [ocu_pkg::DATA_W-1:0] bus_wdata,
    output logic [ocu_pkg::DATA_W-1:0] bus_rdata,
    output logic                       irq
);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(2 * NUM_CH);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * NUM_CH + 1);

    logic [NUM_CH-1:0][CNT_W-1:0] cmp;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0]            mask_q;
    logic [NUM_CH-1:0]            flag;
    logic [NUM_CH-1:0]            clr;
    logic                         wr_mask, wr_flag;

    // Bus decode for the enable and flag bytes.
    always_comb begin
        wr_mask = bus_wr && (bus_addr == MASK_ADDR);
        wr_flag = bus_wr && (bus_addr == FLAG_ADDR);
        for (int i = 0; i < NUM_CH; i++)
            clr[i] = wr_flag && bus_wdata[ocu_pkg::chan_bit(i)];
    end

    // Enable byte storage; only channel bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (wr_mask)
            for (int i = 0; i < NUM_CH; i++)
                mask_q[i] <= bus_wdata[ocu_pkg::chan_bit(i)];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ocu_chan #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .IDX(g)) u_chan (
            .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
            .wdata(bus_wdata), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
            .en(mask_q[g]), .cmp_q(cmp[g]), .hit(hit[g])
        );
    end

    ocu_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(hit), .clr(clr), .flag_q(flag)
    );

    ocu_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rdmux (
        .addr(bus_addr), .cmp(cmp), .mask(mask_q), .flag(flag), .rdata(bus_rdata)
    );

    // Combined interrupt request.
    always_comb begin
        irq = |(flag & mask_q);
    end

    AST_IRQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (hit != '0) && !wr_mask) |-> irq); // R6
    AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == '0) |-> !irq); // R6
endmodule

// File: tb/ocu_top_bench.sv
module ocu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ocu_top u_ocu_top (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // Vector: {req[3:0], kind[1:0], addr[3:0], data[7:0], cnt[15:0]}
    // kind 0 write, 1 tick with count, 2 read check, 3 irq check (data[0])
    localparam int NV = 26;
    localparam logic [33:0] VEC [0:NV-1] = '{
        {4'd2, 2'd0, 4'd10, 8'hF8, 16'h0000},  // R2 enable all
        {4'd1, 2'd0, 4'd0,  8'h12, 16'h0000},  // R1
        {4'd1, 2'd0, 4'd1,  8'h34, 16'h0000},  // R1
        {4'd1, 2'd0, 4'd2,  8'h00, 16'h0000},  // R1
        {4'd1, 2'd0, 4'd3,  8'h10, 16'h0000},  // R1
        {4'd1, 2'd2, 4'd0,  8'h12, 16'h0000},  // R1 readback
        {4'd1, 2'd2, 4'd1,  8'h34, 16'h0000},  // R1
        {4'd1, 2'd2, 4'd3,  8'h10, 16'h0000},  // R1
        {4'd3, 2'd1, 4'd0,  8'h00, 16'h1233},  // R3 one below
        {4'd3, 2'd2, 4'd11, 8'h00, 16'h0000},  // R3
        {4'd3, 2'd1, 4'd0,  8'h00, 16'h1234},  // R3 exact
        {4'd3, 2'd2, 4'd11, 8'h80, 16'h0000},  // R3
        {4'd6, 2'd3, 4'd0,  8'h01, 16'h0000},  // R6 irq up
        {4'd3, 2'd1, 4'd0,  8'h00, 16'h0010},  // R3 second channel
        {4'd3, 2'd2, 4'd11, 8'hC0, 16'h0000},  // R3
        {4'd5, 2'd0, 4'd11, 8'h80, 16'h0000},  // R5 clear ch1
        {4'd5, 2'd2, 4'd11, 8'h40, 16'h0000},  // R5
        {4'd5, 2'd0, 4'd11, 8'h00, 16'h0000},  // R5 zero write
        {4'd5, 2'd2, 4'd11, 8'h40, 16'h0000},  // R5
        {4'd5, 2'd0, 4'd11, 8'h40, 16'h0000},  // R5
        {4'd5, 2'd2, 4'd11, 8'h00, 16'h0000},  // R5
        {4'd6, 2'd3, 4'd0,  8'h00, 16'h0000},  // R6 irq down
        {4'd8, 2'd1, 4'd0,  8'h00, 16'h1234},  // R8 recur
        {4'd8, 2'd2, 4'd11, 8'h80, 16'h0000},  // R8
        {4'd5, 2'd0, 4'd11, 8'hFF, 16'h0000},  // R5 clear all
        {4'd5, 2'd2, 4'd11, 8'h00, 16'h0000}   // R5
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input logic [15:0] v);
        cnt_val = v; cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic wr_tick(input logic [3:0] a, input logic [7:0] d, input logic [15:0] v);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cnt_val = v; cnt_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        chk(req, {7'd0, irq}, {7'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        for (int a = 0; a < 10; a++) rd("R1", 4'(a), 8'hFF);
        rd("R2", 4'd10, 8'h00);
        rd("R2", 4'd11, 8'h00);
        chk_irq("R6", 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            logic [1:0] k;
            rq = $sformatf("R%0d", VEC[i][33:30]);
            k = VEC[i][29:28];
            case (k)
                2'd0: wr(VEC[i][27:24], VEC[i][23:16]);
                2'd1: tick(VEC[i][15:0]);
                2'd2: rd(rq, VEC[i][27:24], VEC[i][23:16]);
                default: chk_irq(rq, VEC[i][16]);
            endcase
        end

        // R4: disabled channel and strobe-low equality
        wr(4'd10, 8'hD8);
        wr(4'd4, 8'h05);
        wr(4'd5, 8'h00);
        tick(16'h0500);
        rd("R4", 4'd11, 8'h00);
        wr(4'd10, 8'hF8);
        rd("R4", 4'd11, 8'h00);
        chk_irq("R4", 1'b0);
        cnt_val = 16'h0500;
        @(negedge clk);
        rd("R4", 4'd11, 8'h00);

        // R2: low bits ignored
        wr(4'd10, 8'hFF);
        rd("R2", 4'd10, 8'hF8);

        // R6: masking does not clear the flag
        tick(16'h0500);
        rd("R3", 4'd11, 8'h20);
        chk_irq("R6", 1'b1);
        wr(4'd10, 8'h00);
        chk_irq("R6", 1'b0);
        rd("R6", 4'd11, 8'h20);
        wr(4'd10, 8'hF8);
        chk_irq("R6", 1'b1);
        wr(4'd11, 8'h20);
        chk_irq("R6", 1'b0);

        // R7: write in the same cycle as a strobe uses the old value
        wr_tick(4'd7, 8'h00, 16'hFF00);
        rd("R7", 4'd11, 8'h00);
        tick(16'hFF00);
        rd("R7", 4'd11, 8'h10);
        wr_tick(4'd9, 8'h00, 16'hFFFF);
        rd("R7", 4'd11, 8'h18);
        wr(4'd11, 8'hFF);
        rd("R5", 4'd11, 8'h00);

        // R5: set wins over clear
        tick(16'h1234);
        rd("R8", 4'd11, 8'h80);
        wr_tick(4'd11, 8'h80, 16'h1234);
        rd("R5", 4'd11, 8'h80);
        wr(4'd11, 8'h80);
        rd("R5", 4'd11, 8'h00);

        // Reset mid-run restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1", 4'd0, 8'hFF);
        rd("R2", 4'd10, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule